// File: doc/BRIEF.md
# Flash Power-Mode Sequencer

This block sequences an embedded flash module between normal operation and two reduced-power modes: a deep power-down mode and a lighter low-power mode. Software asks for a mode by holding a level request bit high and leaves the mode by dropping it. The sequencer watches two handshake inputs from the flash core. One says that a program operation is running and the other says that an erase high-voltage phase is running. A running program operation delays mode entry until it completes. A running erase is suspended at entry and is flagged in a suspend status bit.

While a reduced-power mode is active, and for the whole wake-up delay after it, the sequencer blocks register writes. In the same period it blocks reads of a restricted address window and holds a wait signal against flash array accesses. Each mode has its own wake-up delay, and the power-down delay is the longer one. A suspended erase restarts only when software clears the suspend bit while the high-voltage enable bit is set. If the two modes are requested in a conflicting way, the request is refused and a sticky error flag is set.

Top module: `flash_pwr_seq`

## Requirements
- R1: After reset, ready is 1, pd_active, lp_active, esus and mode_err are 0, and erase_go is 0 while hv_en is 0.
- R2: In normal operation with pgm_busy low, a high pd_req (or lp_req) makes pd_active (or lp_active) 1 and ready 0 one cycle after it is sampled.
- R3: When pd_req and lp_req are both sampled high in the same cycle of normal operation, power-down is entered and low-power is not.
- R4: While pgm_busy is high, entry is deferred and ready stays 1. The mode is entered in the cycle after pgm_busy is sampled low.
- R5: If ers_busy is high in the cycle a mode is entered, esus becomes 1 together with the mode flag. Otherwise it stays 0.
- R6: erase_go equals hv_en AND NOT esus AND ready. A sus_clr pulse clears esus only when it is sampled with ready 1 and hv_en 1. At any other time it is ignored.
- R7: After a mode that interrupted no erase, erase_go again follows hv_en once ready returns, with esus still 0.
- R8: lp_req high during power-down, or pd_req high during low-power, sets mode_err. The current mode flag is unchanged. mode_err stays 1 until reset.
- R9: After the exit request is sampled, ready stays 0 for exactly PD_WAKE cycles (power-down) or LP_WAKE cycles (low-power). The defaults are 64 and 16.
- R10: reg_wr_ok equals reg_wr while ready is 1 and is 0 while ready is 0.
- R11: Addresses RSTR_LO..RSTR_HI (default 8..13) are restricted. reg_rd_ok is 0 for them while ready is 0. Otherwise reg_rd_ok equals reg_rd.
- R12: arr_wait equals arr_req while ready is 0 and is 0 while ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req | input | 1 | Power-down request level |
| lp_req | input | 1 | Low-power request level |
| pgm_busy | input | 1 | Program operation running |
| ers_busy | input | 1 | Erase high-voltage phase running |
| hv_en | input | 1 | High-voltage enable configuration bit |
| sus_clr | input | 1 | Software write clearing the erase-suspend bit |
| reg_wr | input | 1 | Register write attempt |
| reg_rd | input | 1 | Register read attempt |
| reg_addr | input | ADDR_W | Register address |
| arr_req | input | 1 | Flash array access request |
| pd_active | output | 1 | Power-down mode active |
| lp_active | output | 1 | Low-power mode active |
| ready | output | 1 | Normal operation, wake-up complete |
| esus | output | 1 | Erase-suspend status |
| erase_go | output | 1 | Erase allowed to run |
| mode_err | output | 1 | Sticky forbidden-request flag |
| reg_wr_ok | output | 1 | Register write granted |
| reg_rd_ok | output | 1 | Register read granted |
| arr_wait | output | 1 | Array access stalled |

## Verification
The access gate is swept over every address with every read, write and array-request combination in normal operation and in each reduced mode. This shows whether the restricted window is placed correctly and whether read and write locking are kept apart. Every combination of program-busy and erase-busy at entry is tried with a low-power request, which separates deferral from suspension. Wake-up counts are measured for both modes, so swapped or off-by-one delays show up. Conflicting requests are applied in both directions, including the simultaneous case, and suspend clears are tried with the enable bit high, with it low, and inside a mode, to show when a clear takes effect.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_DEFER = 3'd1,
    ST_PD    = 3'd2,
    ST_LP    = 3'd3,
    ST_WAKE  = 3'd4
  } fpm_state_e;
endpackage

// File: rtl/fpm_wake_timer.sv
module fpm_wake_timer #(
  parameter int LP_WAKE = 16,
  parameter int PD_WAKE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic sel_pd_i,
  output logic done_o
);
  localparam int MAXW = (PD_WAKE > LP_WAKE) ? PD_WAKE : LP_WAKE;
  localparam int CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] PD_LD = CW'(PD_WAKE - 1);
  localparam logic [CW-1:0] LP_LD = CW'(LP_WAKE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = sel_pd_i ? PD_LD : LP_LD;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);

  // R9: an idle counter stays idle until reloaded
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> done_o);
endmodule

// File: rtl/fpm_seq_fsm.sv
module fpm_seq_fsm
  import fpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pd_req_i,
  input  logic       lp_req_i,
  input  logic       pgm_busy_i,
  input  logic       ers_busy_i,
  input  logic       hv_en_i,
  input  logic       sus_clr_i,
  input  logic       wake_done_i,
  output fpm_state_e state_o,
  output logic       wake_load_o,
  output logic       wake_sel_pd_o,
  output logic       ready_o,
  output logic       esus_o,
  output logic       err_o
);
  fpm_state_e state_q, state_d;
  logic tgt_pd_q, tgt_pd_d;
  logic esus_q, esus_d;
  logic err_q, err_d;
  logic enter;
  logic tgt_req;

  assign ready_o = (state_q == ST_RUN) || (state_q == ST_DEFER);
  assign tgt_req = tgt_pd_q ? pd_req_i : lp_req_i;

  always_comb begin
    state_d       = state_q;
    tgt_pd_d      = tgt_pd_q;
    enter         = 1'b0;
    wake_load_o   = 1'b0;
    wake_sel_pd_o = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (pd_req_i || lp_req_i) begin
          tgt_pd_d = pd_req_i;
          if (pgm_busy_i) begin
            state_d = ST_DEFER;
          end else begin
            state_d = pd_req_i ? ST_PD : ST_LP;
            enter   = 1'b1;
          end
        end
      end
      ST_DEFER: begin
        if (!tgt_req) begin
          state_d = ST_RUN;
        end else if (!pgm_busy_i) begin
          state_d = tgt_pd_q ? ST_PD : ST_LP;
          enter   = 1'b1;
        end
      end
      ST_PD: begin
        if (!pd_req_i) begin
          state_d       = ST_WAKE;
          wake_load_o   = 1'b1;
          wake_sel_pd_o = 1'b1;
        end
      end
      ST_LP: begin
        if (!lp_req_i) begin
          state_d     = ST_WAKE;
          wake_load_o = 1'b1;
        end
      end
      ST_WAKE: begin
        if (wake_done_i) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_comb begin
    esus_d = esus_q;
    if (enter && ers_busy_i)                   esus_d = 1'b1;
    else if (sus_clr_i && ready_o && hv_en_i)  esus_d = 1'b0;
  end

  always_comb begin
    err_d = err_q
          | ((state_q == ST_PD) & lp_req_i)
          | ((state_q == ST_LP) & pd_req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      tgt_pd_q <= 1'b0;
      esus_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      tgt_pd_q <= tgt_pd_d;
      esus_q   <= esus_d;
      err_q    <= err_d;
    end
  end

  assign state_o = state_q;
  assign esus_o  = esus_q;
  assign err_o   = err_q;

  // R6: without the enable bit the suspend flag cannot be cleared
  p_esus_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (esus_q && !hv_en_i) |=> esus_q);
  // R9: ready only comes back at the end of a wake-up delay
  p_ready_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(state_q) == ST_WAKE));
  // R8: the error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/fpm_access_gate.sv
module fpm_access_gate #(
  parameter int ADDR_W  = 4,
  parameter int RSTR_LO = 8,
  parameter int RSTR_HI = 13
) (
  input  logic              ready_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              arr_req_i,
  output logic              reg_wr_ok_o,
  output logic              reg_rd_ok_o,
  output logic              arr_wait_o
);
  localparam int NADDR = 1 << ADDR_W;

  logic [NADDR-1:0] rstr_map;

  for (genvar a = 0; a < NADDR; a++) begin : g_map
    assign rstr_map[a] = (a >= RSTR_LO) && (a <= RSTR_HI);
  end

  always_comb begin
    reg_wr_ok_o = reg_wr_i && ready_i;
    reg_rd_ok_o = reg_rd_i && (ready_i || !rstr_map[reg_addr_i]);
    arr_wait_o  = arr_req_i && !ready_i;
  end
endmodule

// File: rtl/flash_pwr_seq.sv
module flash_pwr_seq
  import fpm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int RSTR_LO = 8,
  parameter int RSTR_HI = 13,
  parameter int LP_WAKE = 16,
  parameter int PD_WAKE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_req,
  input  logic              lp_req,
  input  logic              pgm_busy,
  input  logic              ers_busy,
  input  logic              hv_en,
  input  logic              sus_clr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              arr_req,
  output logic              pd_active,
  output logic              lp_active,
  output logic              ready,
  output logic              esus,
  output logic              erase_go,
  output logic              mode_err,
  output logic              reg_wr_ok,
  output logic              reg_rd_ok,
  output logic              arr_wait
);
  fpm_state_e state;
  logic wake_load, wake_sel_pd, wake_done;

  fpm_seq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pd_req_i      (pd_req),
    .lp_req_i      (lp_req),
    .pgm_busy_i    (pgm_busy),
    .ers_busy_i    (ers_busy),
    .hv_en_i       (hv_en),
    .sus_clr_i     (sus_clr),
    .wake_done_i   (wake_done),
    .state_o       (state),
    .wake_load_o   (wake_load),
    .wake_sel_pd_o (wake_sel_pd),
    .ready_o       (ready),
    .esus_o        (esus),
    .err_o         (mode_err)
  );

  fpm_wake_timer #(.LP_WAKE(LP_WAKE), .PD_WAKE(PD_WAKE)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (wake_load),
    .sel_pd_i (wake_sel_pd),
    .done_o   (wake_done)
  );

  fpm_access_gate #(.ADDR_W(ADDR_W), .RSTR_LO(RSTR_LO), .RSTR_HI(RSTR_HI)) u_gate (
    .ready_i     (ready),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .arr_req_i   (arr_req),
    .reg_wr_ok_o (reg_wr_ok),
    .reg_rd_ok_o (reg_rd_ok),
    .arr_wait_o  (arr_wait)
  );

  assign pd_active = (state == ST_PD);
  assign lp_active = (state == ST_LP);
  assign erase_go  = hv_en && !esus && ready;

  // R10: no write is granted inside a reduced-power mode
  p_wr_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active || lp_active) |-> !reg_wr_ok);
  // R11: restricted reads are refused in power-down
  p_rd_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && reg_rd && (int'(reg_addr) >= RSTR_LO) && (int'(reg_addr) <= RSTR_HI))
      |-> !reg_rd_ok);
  // R4: a running program keeps the module out of both modes
  p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_busy && ready) |=> !(pd_active || lp_active));
  // R5: an erase in flight at entry is flagged as suspended
  p_esus_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_active || lp_active) && $past(ers_busy)) |-> esus);
  // R8: a forbidden low-power request never switches modes
  p_forbid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && lp_req) |=> (mode_err && !lp_active));
  // R12: array accesses are stalled whenever not ready
  p_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && (pd_active || lp_active)) |-> arr_wait);
endmodule

// File: tb/tb_flash_pwr_seq.sv
`timescale 1ns/1ps
module tb_flash_pwr_seq;
  localparam int ADDR_W = 4;
  localparam int LO = 8;
  localparam int HI = 13;
  localparam int LPW = 16;
  localparam int PDW = 64;

  logic clk = 1'b0;
  logic rst_n;
  logic pd_req, lp_req, pgm_busy, ers_busy, hv_en, sus_clr;
  logic reg_wr, reg_rd, arr_req;
  logic [ADDR_W-1:0] reg_addr;
  logic pd_active, lp_active, ready, esus, erase_go, mode_err;
  logic reg_wr_ok, reg_rd_ok, arr_wait;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_pwr_seq #(.ADDR_W(ADDR_W), .RSTR_LO(LO), .RSTR_HI(HI),
                  .LP_WAKE(LPW), .PD_WAKE(PDW)) dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .lp_req(lp_req),
    .pgm_busy(pgm_busy), .ers_busy(ers_busy), .hv_en(hv_en), .sus_clr(sus_clr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .arr_req(arr_req),
    .pd_active(pd_active), .lp_active(lp_active), .ready(ready), .esus(esus),
    .erase_go(erase_go), .mode_err(mode_err), .reg_wr_ok(reg_wr_ok),
    .reg_rd_ok(reg_rd_ok), .arr_wait(arr_wait)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pd_req = 0; lp_req = 0; pgm_busy = 0; ers_busy = 0; hv_en = 0; sus_clr = 0;
    reg_wr = 0; reg_rd = 0; arr_req = 0; reg_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step();
  endtask

  task automatic sweep_access(input bit rdy, input string tag);
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      for (int m = 0; m < 8; m++) begin
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        reg_wr = m[0]; reg_rd = m[1]; arr_req = m[2];
        #2;
        chk({tag, " R10 wr"}, int'(reg_wr_ok), int'(m[0] && rdy));
        chk({tag, " R11 rd"}, int'(reg_rd_ok),
            int'(m[1] && (rdy || !(a >= LO && a <= HI))));
        chk({tag, " R12 wait"}, int'(arr_wait), int'(m[2] && !rdy));
      end
    end
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; arr_req = 0;
  endtask

  task automatic measure_wake(input int exp, input string tag);
    int n;
    n = 0;
    arr_req = 1'b1;
    forever begin
      step();
      if (ready) break;
      chk({tag, " R12 wait during wake"}, int'(arr_wait), 1);
      n++;
    end
    chk({tag, " R9 wake cycles"}, n, exp);
    chk({tag, " R12 wait after wake"}, int'(arr_wait), 0);
    @(negedge clk);
    arr_req = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); sus_clr = 1'b1;
    @(negedge clk); sus_clr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    // R1 reset state
    chk("R1 ready", int'(ready), 1);
    chk("R1 pd_active", int'(pd_active), 0);
    chk("R1 lp_active", int'(lp_active), 0);
    chk("R1 esus", int'(esus), 0);
    chk("R1 mode_err", int'(mode_err), 0);
    chk("R1 erase_go", int'(erase_go), 0);
    sweep_access(1'b1, "run");

    // R2 power-down entry, access locking, R8 forbidden request, R9 wake
    @(negedge clk); pd_req = 1'b1;
    step();
    chk("R2 pd entry", int'(pd_active), 1);
    chk("R2 ready low in pd", int'(ready), 0);
    sweep_access(1'b0, "pd");
    @(negedge clk); lp_req = 1'b1;
    step();
    chk("R8 err from lp in pd", int'(mode_err), 1);
    chk("R8 pd kept", int'(pd_active), 1);
    chk("R8 lp not entered", int'(lp_active), 0);
    @(negedge clk); lp_req = 1'b0;
    step();
    chk("R8 err sticky", int'(mode_err), 1);
    @(negedge clk); pd_req = 1'b0;
    measure_wake(PDW, "pd");
    chk("R8 err still set", int'(mode_err), 1);

    // low-power entry and forbidden power-down request
    do_reset();
    @(negedge clk); lp_req = 1'b1;
    step();
    chk("R2 lp entry", int'(lp_active), 1);
    chk("R2 pd not set", int'(pd_active), 0);
    sweep_access(1'b0, "lp");
    @(negedge clk); pd_req = 1'b1;
    step();
    chk("R8 err from pd in lp", int'(mode_err), 1);
    chk("R8 lp kept", int'(lp_active), 1);
    chk("R8 pd not entered", int'(pd_active), 0);
    @(negedge clk); pd_req = 1'b0;
    step();
    @(negedge clk); lp_req = 1'b0;
    measure_wake(LPW, "lp");

    // R3 simultaneous requests
    do_reset();
    @(negedge clk); pd_req = 1'b1; lp_req = 1'b1;
    step();
    chk("R3 pd wins", int'(pd_active), 1);
    chk("R3 lp loses", int'(lp_active), 0);
    @(negedge clk); lp_req = 1'b0;
    step();
    @(negedge clk); pd_req = 1'b0;
    measure_wake(PDW, "both");

    // R4/R5 sweep of program and erase activity at entry
    for (int c = 0; c < 4; c++) begin
      do_reset();
      @(negedge clk);
      hv_en = 1'b1; ers_busy = c[0]; pgm_busy = c[1]; lp_req = 1'b1;
      if (c[1]) begin
        repeat (3) begin
          step();
          chk("R4 deferred", int'(lp_active), 0);
          chk("R4 ready during defer", int'(ready), 1);
        end
        @(negedge clk); pgm_busy = 1'b0;
      end
      step();
      chk("R4 entered", int'(lp_active), 1);
      chk("R5 esus at entry", int'(esus), int'(c[0]));
      @(negedge clk); ers_busy = 1'b0;
      chk("R6 erase_go off in mode", int'(erase_go), 0);
      @(negedge clk); lp_req = 1'b0;
      measure_wake(LPW, "sweep");
      chk("R7/R6 erase_go after wake", int'(erase_go), int'(!c[0]));
      chk("R7 esus kept", int'(esus), int'(c[0]));
    end

    // R6 suspend clear rules
    do_reset();
    @(negedge clk); hv_en = 1'b1; ers_busy = 1'b1;
    #1;
    chk("R6 erase_go running", int'(erase_go), 1);
    @(negedge clk); pd_req = 1'b1;
    step();
    chk("R5 esus set in pd", int'(esus), 1);
    @(negedge clk); ers_busy = 1'b0;
    pulse_clr();
    chk("R6 clear ignored in mode", int'(esus), 1);
    @(negedge clk); pd_req = 1'b0;
    measure_wake(PDW, "sus");
    chk("R6 erase_go blocked by esus", int'(erase_go), 0);
    @(negedge clk); hv_en = 1'b0;
    pulse_clr();
    chk("R6 clear ignored with hv_en low", int'(esus), 1);
    @(negedge clk); hv_en = 1'b1;
    pulse_clr();
    chk("R6 clear accepted", int'(esus), 0);
    chk("R6 erase resumes", int'(erase_go), 1);
    @(negedge clk); hv_en = 1'b0;
    #1;
    chk("R6 erase_go follows hv_en", int'(erase_go), 0);

    finish_run();
  end
endmodule